// File: doc/BRIEF.md
# Baud Tick Generator with Selectable Prescale

This block turns a single functional clock into the per-bit timing strobe that a serial transmitter and receiver share. It reads a configuration word holding a 23-bit divisor, an enable bit and a source-select bit. Every bit period it emits a pulse one clock wide. Two source paths exist. In direct mode a fixed divide-by-4 stage feeds the divisor counter, which matches a software setting of round(clock / (4 x rate)) - 1. In crystal mode a fixed divide-by-3 stage feeds the same counter, which matches a setting of (clock / 3 / rate) - 1. The crystal path is modelled as a clock enable on the one clock.

Without the enable bit the generator runs on a built-in default divisor through the direct path, and a status output shows whether the programmed word is in force. A new word never changes a bit period that is already running. It is sampled at the terminal count, so the period that follows is the first to use it. Rates from 9600 to 4,000,000 bit/s are within reach of the 23-bit field.

Top module: `baud_tick_gen`

## Requirements
- R1: With bit 23 of `baud_cfg` set and bit 24 clear, the spacing between `bit_tick` pulses is 4 x (D + 1) clock cycles, where D is `baud_cfg[22:0]`.
- R2: With bits 23 and 24 both set, the spacing is 3 x (D + 1) clock cycles.
- R3: With bit 23 clear, bits 24 and [22:0] are ignored and the spacing is 4 x (DEFAULT_DIV + 1) cycles (64 with the default DEFAULT_DIV of 15).
- R4: `cfg_active` is 1 during exactly those bit periods that run on a programmed word (bit 23 set when the period began), and 0 otherwise.
- R5: A change to `baud_cfg` during a bit period leaves that period's length and `cfg_active` unchanged. The new word governs the period that starts after the next pulse.
- R6: `bit_tick` is high for exactly one clock cycle per period.
- R7: After reset, `bit_tick` and `cfg_active` are 0, and the first period runs on the default divisor. That first pulse comes 4 x (DEFAULT_DIV + 1) - 1 cycles after reset release, measured in rising edges.
- R8: A divisor of 0 is legal: the spacing is 4 cycles in direct mode and 3 cycles in crystal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_cfg | input | DIV_W+2 | [22:0] divisor, [23] use programmed word, [24] crystal source select |
| bit_tick | output | 1 | One-cycle pulse at every bit boundary |
| cfg_active | output | 1 | The current period runs on the programmed word |

## Verification
The divisor is tried at 0, at small values and at values in the hundreds and thousands, in both source modes. This separates the divide-by-3 path from the divide-by-4 path and exposes any off-by-one in the D + 1 count, including the case where the prescaler alone sets the period. One word has the enable bit clear while the select bit and divisor hold nonzero values, so the fallback to the default divisor is distinguished from a partial decode. Every word is applied in the middle of a running period, so a design that loads early shortens or lengthens that period and shows up in the measured spacing.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Number of functional clocks per source tick for the selected path.
  function automatic int unsigned src_ratio(input logic xtal_sel,
                                            input int unsigned direct_ratio,
                                            input int unsigned xtal_ratio);
    return xtal_sel ? xtal_ratio : direct_ratio;
  endfunction

  // Clock cycles in one bit period for a divisor and path.
  function automatic longint unsigned bit_period(input logic xtal_sel,
                                                 input longint unsigned div,
                                                 input int unsigned direct_ratio,
                                                 input int unsigned xtal_ratio);
    return longint'(src_ratio(xtal_sel, direct_ratio, xtal_ratio)) * (div + 1);
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned DIRECT_DIV = 4,
  parameter int unsigned XTAL_DIV   = 3,
  localparam int unsigned MAXP      = (DIRECT_DIV > XTAL_DIV) ? DIRECT_DIV : XTAL_DIV,
  localparam int unsigned PW        = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_sel,
  output logic          src_tick,
  output logic [PW-1:0] pre_cnt
);
  import baud_tick_pkg::*;

  logic [PW-1:0] limit;

  always_comb begin
    limit    = PW'(src_ratio(xtal_sel, DIRECT_DIV, XTAL_DIV) - 1);
    src_tick = (pre_cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (src_tick) pre_cnt <= '0;
    else               pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned DIV_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] act_div,
  output logic [DIV_W-1:0] div_cnt,
  output logic             terminal
);
  assign terminal = src_tick && (div_cnt == act_div);

  always_ff @(posedge clk) begin
    if (!rst_n)        div_cnt <= '0;
    else if (terminal) div_cnt <= '0;
    else if (src_tick) div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/baud_cfg_hold.sv
module baud_cfg_hold #(
  parameter int unsigned DIV_W       = 23,
  parameter int unsigned DEFAULT_DIV = 15,
  localparam int unsigned USE_BIT    = DIV_W,
  localparam int unsigned XTAL_BIT   = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W+1:0] baud_cfg,
  input  logic             load,
  output logic [DIV_W-1:0] act_div,
  output logic             act_xtal,
  output logic             act_use
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div  <= DIV_W'(DEFAULT_DIV);
      act_xtal <= 1'b0;
      act_use  <= 1'b0;
    end else if (load) begin
      if (baud_cfg[USE_BIT]) begin
        act_div  <= baud_cfg[DIV_W-1:0];
        act_xtal <= baud_cfg[XTAL_BIT];
        act_use  <= 1'b1;
      end else begin
        act_div  <= DIV_W'(DEFAULT_DIV);
        act_xtal <= 1'b0;
        act_use  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV_W       = 23,
  parameter int unsigned DEFAULT_DIV = 15,
  parameter int unsigned DIRECT_DIV  = 4,
  parameter int unsigned XTAL_DIV    = 3,
  localparam int unsigned MAXP       = (DIRECT_DIV > XTAL_DIV) ? DIRECT_DIV : XTAL_DIV,
  localparam int unsigned PW         = $clog2(MAXP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W+1:0] baud_cfg,
  output logic             bit_tick,
  output logic             cfg_active
);
  logic             src_tick;
  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] div_cnt;
  logic             act_xtal;
  logic             act_use;
  logic             terminal;

  baud_cfg_hold #(.DIV_W(DIV_W), .DEFAULT_DIV(DEFAULT_DIV)) u_hold (
    .clk(clk), .rst_n(rst_n), .baud_cfg(baud_cfg), .load(terminal),
    .act_div(act_div), .act_xtal(act_xtal), .act_use(act_use)
  );

  baud_prescaler #(.DIRECT_DIV(DIRECT_DIV), .XTAL_DIV(XTAL_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .xtal_sel(act_xtal),
    .src_tick(src_tick), .pre_cnt(pre_cnt)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .act_div(act_div),
    .div_cnt(div_cnt), .terminal(terminal)
  );

  assign bit_tick   = terminal;
  assign cfg_active = act_use;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned DIV_W       = 23,
  parameter int unsigned DEFAULT_DIV = 15,
  parameter int unsigned DIRECT_DIV  = 4,
  parameter int unsigned XTAL_DIV    = 3,
  parameter int unsigned PW          = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W+1:0] baud_cfg,
  input logic             bit_tick,
  input logic             cfg_active,
  input logic             src_tick,
  input logic [PW-1:0]    pre_cnt,
  input logic [DIV_W-1:0] act_div,
  input logic [DIV_W-1:0] div_cnt,
  input logic             act_xtal
);
  assert_tick_on_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> src_tick);

  assert_div_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= act_div);

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_cnt) <= (act_xtal ? int'(XTAL_DIV) - 1 : int'(DIRECT_DIV) - 1));

  assert_default_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !baud_cfg[DIV_W]) |=> (act_div == DIV_W'(DEFAULT_DIV) && !act_xtal));

  assert_active_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (cfg_active == $past(baud_cfg[DIV_W])));

  assert_hold_mid_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(act_div) && $stable(act_xtal) && $stable(cfg_active)));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .DIV_W(DIV_W), .DEFAULT_DIV(DEFAULT_DIV), .DIRECT_DIV(DIRECT_DIV),
  .XTAL_DIV(XTAL_DIV), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_cfg(baud_cfg), .bit_tick(bit_tick),
  .cfg_active(cfg_active), .src_tick(src_tick), .pre_cnt(pre_cnt),
  .act_div(act_div), .div_cnt(div_cnt), .act_xtal(act_xtal)
);

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;
  localparam int DIV_W = 23;

  typedef struct {
    int period;
    bit active;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W+1:0] baud_cfg = '0;
  logic             bit_tick;
  logic             cfg_active;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   last_tick = -1;
  bit   prev_tick = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .baud_cfg(baud_cfg),
    .bit_tick(bit_tick), .cfg_active(cfg_active)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic [DIV_W+1:0] mk(bit use_w, bit xtal, int div);
    return {xtal, use_w, DIV_W'(div)};
  endfunction

  // Independent restatement: default 15, ratio 4 direct / 3 crystal.
  function automatic exp_t expect_of(logic [DIV_W+1:0] w);
    exp_t e;
    if (!w[DIV_W]) begin
      e.period = 4 * 16;
      e.active = 1'b0;
    end else begin
      e.period = (w[DIV_W+1] ? 3 : 4) * (int'(w[DIV_W-1:0]) + 1);
      e.active = 1'b1;
    end
    return e;
  endfunction

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!bit_tick);
    end
  endtask

  // Apply a word mid-period (R5) and queue n periods that use it.
  task automatic apply(logic [DIV_W+1:0] w, int n, string tag);
    exp_t e;
    e = expect_of(w);
    baud_cfg = w;
    for (int i = 0; i < n; i++) q.push_back(e);
    $display("step %s: period %0d active %0d x%0d", tag, e.period, e.active, n);
    wait_ticks(n);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_tick && bit_tick) begin
        checks++; errors++;
        $display("FAIL R6: tick high two cycles, actual 2 expected 1 at cyc %0d", cyc);
      end
      if (bit_tick) begin
        exp_t e;
        int got;
        got = cyc - last_tick;
        last_tick = cyc;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R5: unexpected tick, actual interval %0d expected none", got);
        end else begin
          e = q.pop_front();
          if (got != e.period) begin
            errors++;
            $display("FAIL R1/R2/R3/R8: interval actual %0d expected %0d", got, e.period);
          end
          checks++;
          if (cfg_active != e.active) begin
            errors++;
            $display("FAIL R4: cfg_active actual %0d expected %0d", cfg_active, e.active);
          end
        end
      end
      prev_tick = bit_tick;
    end
  end

  initial begin
    exp_t e0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state, first period on default divisor
    checks++;
    if (bit_tick !== 1'b0 || cfg_active !== 1'b0) begin
      errors++;
      $display("FAIL R7: after reset tick/active actual %0d/%0d expected 0/0", bit_tick, cfg_active);
    end
    e0.period = 64; e0.active = 1'b0;
    q.push_back(e0);
    @(negedge clk); @(negedge clk);
    apply(mk(1, 0, 9),    3, "R1 direct D=9");
    apply(mk(1, 1, 9),    3, "R2 crystal D=9");
    apply(mk(1, 1, 0),    4, "R8 crystal D=0");
    apply(mk(1, 0, 0),    2, "R8 direct D=0");
    apply(mk(0, 1, 5),    2, "R3 enable clear, others ignored");
    apply(mk(1, 0, 200),  2, "R1 direct D=200");
    apply(mk(1, 1, 1000), 1, "R2 crystal D=1000");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual 100000 cycles expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule